// File: doc/BRIEF.md
# Receive Packet FIFO with Overflow Marking

This block is a receive packet buffer that sits between an Ethernet MAC receiver and fabric logic. The receiver pushes 32-bit words with a one-clock write strobe. It marks the first and final word of each frame and raises an error flag together with the final word. With that final word it also hands over a status word: the low 14 bits give the frame length in bytes and bit 14 marks a bad frame. The buffer keeps a frame invisible to the reader until its final word has been accepted. Only frames that end cleanly reach the read side.

The buffer holds two write pointers. The first marks where the frame in progress began. The second marks where the next word will land. If a frame ends with an error or a bad-frame mark, or loses words to a full buffer, the second pointer is moved back to the first, so the frame's words are discarded in a single cycle. When a framed word finds no room, it is refused and the overflow output pulses on the next clock. The writer keeps sending the rest of the frame, which is then dropped at its final word. A flush input empties the buffer at once. This includes a partial frame that will never see a final word.

The read side is a valid/ready word stream. Each word carries a last marker, and the length field is filled only on the last word.

Top module: `rx_pkt_fifo`

## Requirements
- R1: While and after reset, with no write, rd_valid and wr_overflow are low.
- R2: A frame written as start word, middle words and an end word, with wr_err low and wr_status[14] low on the end word, is read out word by word in order. rd_last is high only on its end word. rd_len equals wr_status[13:0] of the end write on that word and is zero on every other word.
- R3: No word of a frame is offered on the read side before its end write. On an empty buffer, rd_valid rises in the clock cycle right after the end write.
- R4: A frame whose end write has wr_err high is discarded entirely and never appears on the read side.
- R5: A frame whose end write has wr_status[14] high is discarded entirely.
- R6: A write with wr_sop low while no frame is open is ignored.
- R7: A second start write before an end write discards the partial frame, and a new frame begins with that word.
- R8: The buffer holds DEPTH words, counting the words of the frame still open. A framed write that finds DEPTH words held is refused, and wr_overflow is high in exactly the next cycle. The frame is then discarded at its end write, so overflow is never reported later than one cycle after that end write.
- R9: Once a word of the open frame has been refused, none of its later words are stored, even if reads free space in the meantime.
- R10: A cycle with flush high empties the buffer, including committed frames and the open frame. rd_valid is low in that cycle and the next. Writes without a start marker after the flush are ignored.
- R11: A write strobe in a cycle with flush high is ignored, even one carrying a start marker.
- R12: While rd_valid is high and rd_ready is low, the offered word, its last marker and its length hold steady until taken or flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all contents this cycle |
| wr_en | input | 1 | One-clock write strobe |
| wr_data | input | 32 | Write data word |
| wr_sop | input | 1 | First word of a frame |
| wr_eop | input | 1 | Final word of a frame |
| wr_err | input | 1 | Frame error, valid with wr_eop |
| wr_status | input | 15 | [13:0] frame length in bytes, [14] bad frame; used with wr_eop |
| wr_overflow | output | 1 | A framed write in the previous cycle was refused |
| rd_valid | output | 1 | A committed word is offered |
| rd_ready | input | 1 | Reader accepts the offered word |
| rd_data | output | 32 | Offered data word |
| rd_last | output | 1 | Offered word ends its frame |
| rd_len | output | 14 | Frame length on the last word, zero otherwise |

## Verification
The bench keeps a behavioural model of committed and pending frames and compares it with the outputs every cycle. Clean frames read with the reader always ready show the commit latency and the ordering. The same frames held back with the reader stalled show that output stays steady. Frames ending with an error or a bad mark, stray writes and a repeated start marker show which frames are discarded and which are kept. A frame too large for the buffer, and a frame that overflows while the reader later frees space, show when the overflow pulse appears and that the rest of the frame is dropped. A flush in the middle of a frame, with writes on and after the flush cycle, is followed by a long randomized run with random backpressure.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 14;
  localparam int STAT_W = LEN_W + 1;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              last;
    logic [LEN_W-1:0]  len;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         waddr,
  input  rxq_pkg::rxq_entry_t       wentry,
  input  logic [ADDR_W-1:0]         raddr,
  output rxq_pkg::rxq_entry_t       rentry
);
  rxq_pkg::rxq_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wentry;
  end

  assign rentry = mem[raddr];
endmodule

// File: rtl/rxq_wr_ctrl.sv
module rxq_wr_ctrl #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic              wr_err,
  input  logic              wr_bad,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  cmt_ptr,
  output logic              ovf_pulse
);
  logic [PTR_W-1:0] wr_ptr_n, cmt_ptr_n, base, used;
  logic             in_frame, in_frame_n, ovf_flag, ovf_n, pulse_n;
  logic             room, store, upd_en;

  always_comb begin
    wr_ptr_n   = wr_ptr;
    cmt_ptr_n  = cmt_ptr;
    in_frame_n = in_frame;
    ovf_n      = ovf_flag;
    pulse_n    = 1'b0;
    store      = 1'b0;
    base       = wr_sop ? cmt_ptr : wr_ptr;
    used       = base - rd_ptr;
    room       = (used != PTR_W'(DEPTH));
    if (flush) begin
      wr_ptr_n   = '0;
      cmt_ptr_n  = '0;
      in_frame_n = 1'b0;
      ovf_n      = 1'b0;
    end else if (wr_en && (wr_sop || in_frame)) begin
      if (wr_sop) begin
        in_frame_n = 1'b1;
        store      = room;
        ovf_n      = !room;
      end else begin
        store      = room && !ovf_flag;
        ovf_n      = ovf_flag || !room;
      end
      pulse_n  = !store;
      wr_ptr_n = store ? base + PTR_W'(1) : base;
      if (wr_eop && !wr_sop) begin
        in_frame_n = 1'b0;
        ovf_n      = 1'b0;
        if (store && !wr_err && !wr_bad) cmt_ptr_n = base + PTR_W'(1);
        else                             wr_ptr_n  = cmt_ptr;
      end
    end
  end

  assign upd_en    = flush || wr_en;
  assign mem_we    = store;
  assign mem_waddr = base[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      cmt_ptr   <= '0;
      in_frame  <= 1'b0;
      ovf_flag  <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= pulse_n;
      if (upd_en) begin
        wr_ptr   <= wr_ptr_n;
        cmt_ptr  <= cmt_ptr_n;
        in_frame <= in_frame_n;
        ovf_flag <= ovf_n;
      end
    end
  end

  // R8: an overflow pulse is always caused by a write one cycle earlier
  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(wr_en));

  // R4: the commit point moves only on flush or on a clean end write
  assert_commit_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_ptr != $past(cmt_ptr)) |-> ($past(flush) || $past(wr_en && wr_eop && !wr_err)));
endmodule

// File: rtl/rxq_rd_ctrl.sv
module rxq_rd_ctrl #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [PTR_W-1:0]  cmt_ptr,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [PTR_W-1:0]  rd_ptr
);
  logic [PTR_W-1:0] rd_ptr_n;
  logic             advance;

  assign rd_valid = (rd_ptr != cmt_ptr) && !flush;
  assign advance  = rd_valid && rd_ready;

  always_comb begin
    rd_ptr_n = rd_ptr;
    if (flush)        rd_ptr_n = '0;
    else if (advance) rd_ptr_n = rd_ptr + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_ptr <= '0;
    else if (flush || advance) rd_ptr <= rd_ptr_n;
  end

  // R10: nothing is offered in the cycle after a flush
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_valid);
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo #(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         wr_en,
  input  logic [rxq_pkg::DATA_W-1:0]   wr_data,
  input  logic                         wr_sop,
  input  logic                         wr_eop,
  input  logic                         wr_err,
  input  logic [rxq_pkg::STAT_W-1:0]   wr_status,
  output logic                         wr_overflow,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  output logic [rxq_pkg::DATA_W-1:0]   rd_data,
  output logic                         rd_last,
  output logic [rxq_pkg::LEN_W-1:0]    rd_len
);
  import rxq_pkg::*;

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;

  logic              rst_n_s, mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [PTR_W-1:0]  wr_ptr, cmt_ptr, rd_ptr;
  rxq_entry_t        wentry, rentry;

  rxq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign wentry.data = wr_data;
  assign wentry.last = wr_eop;
  assign wentry.len  = wr_eop ? wr_status[LEN_W-1:0] : '0;

  rxq_wr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_wr (
    .clk(clk), .rst_n(rst_n_s), .flush(flush), .wr_en(wr_en),
    .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_err(wr_err), .wr_bad(wr_status[LEN_W]),
    .rd_ptr(rd_ptr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .wr_ptr(wr_ptr), .cmt_ptr(cmt_ptr), .ovf_pulse(wr_overflow)
  );

  rxq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wentry(wentry),
    .raddr(rd_ptr[ADDR_W-1:0]), .rentry(rentry)
  );

  rxq_rd_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_rd (
    .clk(clk), .rst_n(rst_n_s), .flush(flush), .cmt_ptr(cmt_ptr),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_ptr(rd_ptr)
  );

  assign rd_data = rentry.data;
  assign rd_last = rentry.last;
  assign rd_len  = rentry.len;

  // R8: held words, committed or pending, never exceed the capacity
  assert_occupancy_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((wr_ptr - rd_ptr) <= PTR_W'(DEPTH)) && ((cmt_ptr - rd_ptr) <= (wr_ptr - rd_ptr)));

  // R12: an offered word waits unchanged for the reader
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_valid && !rd_ready) |=> (flush || (rd_valid && $stable(rd_data)
                                  && $stable(rd_last) && $stable(rd_len))));
endmodule

// File: tb/rx_pkt_fifo_tb_top.sv
module rx_pkt_fifo_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, wr_en = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, wr_err = 1'b0;
  logic [31:0] wr_data = '0;
  logic [14:0] wr_status = '0;
  logic        rd_ready = 1'b0;
  logic        wr_overflow, rd_valid, rd_last;
  logic [31:0] rd_data;
  logic [13:0] rd_len;

  always #5 clk = ~clk;

  rx_pkt_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_err(wr_err), .wr_status(wr_status),
    .wr_overflow(wr_overflow), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last), .rd_len(rd_len)
  );

  typedef struct { logic [31:0] d; logic l; logic [13:0] n; } ent_t;
  ent_t  cq[$], pq[$], e;
  bit    m_in, m_ovf, m_pulse, pop, room, st;
  int    n_chk, n_fail, ready_mode;
  string cur_req = "R1";

  // behavioural reference, advanced on every clock
  always @(posedge clk) begin
    if (!rst_n) begin
      cq.delete(); pq.delete(); m_in = 0; m_ovf = 0; m_pulse = 0;
    end else if (flush) begin
      cq.delete(); pq.delete(); m_in = 0; m_ovf = 0; m_pulse = 0;
    end else begin
      pop = (cq.size() > 0) && rd_ready;
      m_pulse = 0;
      e.d = wr_data; e.l = wr_eop; e.n = wr_eop ? wr_status[13:0] : 14'd0;
      if (wr_en && wr_sop) begin
        pq.delete(); m_in = 1;
        st = cq.size() < DEPTH;
        m_ovf = !st;
        if (st) pq.push_back(e);
        m_pulse = !st;
      end else if (wr_en && m_in) begin
        room = (cq.size() + pq.size()) < DEPTH;
        st = room && !m_ovf;
        if (!room) m_ovf = 1;
        if (st) pq.push_back(e);
        m_pulse = !st;
        if (wr_eop) begin
          m_in = 0;
          if (st && !wr_err && !wr_status[14]) foreach (pq[i]) cq.push_back(pq[i]);
          pq.delete(); m_ovf = 0;
        end
      end
      if (pop) void'(cq.pop_front());
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // compare away from both edges
  always @(negedge clk) begin
    #2;
    chk("rd_valid", {31'd0, rd_valid}, {31'd0, (cq.size() > 0) && !flush});
    chk("wr_overflow", {31'd0, wr_overflow}, {31'd0, m_pulse});
    if (cq.size() > 0 && !flush) begin
      chk("rd_data", rd_data, cq[0].d);
      chk("rd_last", {31'd0, rd_last}, {31'd0, cq[0].l});
      chk("rd_len", {18'd0, rd_len}, {18'd0, cq[0].n});
    end
  end

  always @(negedge clk) begin
    case (ready_mode)
      0:       rd_ready <= 1'b0;
      1:       rd_ready <= 1'b1;
      default: rd_ready <= 1'($urandom % 2);
    endcase
  end

  task automatic put(bit s, bit eo, bit er, bit bad, logic [31:0] d, int len);
    @(negedge clk);
    wr_en = 1; wr_sop = s; wr_eop = eo; wr_err = er; wr_data = d;
    wr_status = {bad, 14'(len)};
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 0; wr_sop = 0; wr_eop = 0; wr_err = 0; flush = 0;
    end
  endtask

  task automatic frame(int n, bit er, bit bad, logic [31:0] tag);
    for (int i = 0; i < n; i++)
      put(i == 0, i == n - 1, er && (i == n - 1), bad && (i == n - 1), tag + 32'(i), n * 4 - 1);
    idle(1);
  endtask

  initial begin
    ready_mode = 1;
    cur_req = "R1";                       // reset state
    idle(4); rst_n = 1; idle(6);
    cur_req = "R2";                       // clean frames, reader ready
    frame(4, 0, 0, 32'h1000); frame(1, 0, 0, 32'h1100); idle(6);
    cur_req = "R3";                       // visibility only after end write
    ready_mode = 0; frame(3, 0, 0, 32'h2000);
    cur_req = "R12";                      // stalled reader holds output
    idle(5); ready_mode = 1; idle(6);
    cur_req = "R4";                       // error on end word
    frame(3, 1, 0, 32'h3000); frame(2, 0, 0, 32'h3100); idle(5);
    cur_req = "R5";                       // bad-frame status bit
    frame(4, 0, 1, 32'h4000); frame(2, 0, 0, 32'h4100); idle(5);
    cur_req = "R6";                       // stray writes outside a frame
    put(0, 0, 0, 0, 32'h5000, 0); put(0, 1, 0, 0, 32'h5001, 7); idle(3);
    frame(2, 0, 0, 32'h5100); idle(4);
    cur_req = "R7";                       // repeated start marker
    put(1, 0, 0, 0, 32'h6000, 0); put(0, 0, 0, 0, 32'h6001, 0);
    frame(3, 0, 0, 32'h6100); idle(5);
    cur_req = "R8";                       // frame larger than capacity
    ready_mode = 0; frame(10, 0, 0, 32'h7000); idle(3);
    frame(8, 0, 0, 32'h7100); frame(2, 0, 0, 32'h7200);
    ready_mode = 1; idle(12);
    cur_req = "R9";                       // space freed after a refusal
    ready_mode = 0; frame(6, 0, 0, 32'h8000);
    put(1, 0, 0, 0, 32'h8100, 0); put(0, 0, 0, 0, 32'h8101, 0); put(0, 0, 0, 0, 32'h8102, 0);
    ready_mode = 1;
    put(0, 0, 0, 0, 32'h8103, 0); put(0, 0, 0, 0, 32'h8104, 0); idle(4);
    put(0, 1, 0, 0, 32'h8105, 23); idle(6);
    frame(3, 0, 0, 32'h8200); idle(5);
    cur_req = "R10";                      // flush mid-frame
    ready_mode = 0; frame(3, 0, 0, 32'h9000);
    put(1, 0, 0, 0, 32'h9100, 0); put(0, 0, 0, 0, 32'h9101, 0);
    cur_req = "R11";                      // write on the flush cycle
    @(negedge clk); flush = 1; wr_en = 1; wr_sop = 1; wr_eop = 0; wr_data = 32'h9200;
    idle(2);
    cur_req = "R10";
    put(0, 0, 0, 0, 32'h9300, 0); put(0, 1, 0, 0, 32'h9301, 7); idle(2);
    ready_mode = 1; frame(2, 0, 0, 32'h9400); idle(5);
    cur_req = "R2";                       // randomized traffic and backpressure
    ready_mode = 2;
    for (int f = 0; f < 60; f++) begin
      frame(1 + int'($urandom % 7), ($urandom % 6) == 0, ($urandom % 7) == 0, 32'hA000 + 32'(f * 16));
      idle(int'($urandom % 3));
    end
    ready_mode = 1; idle(30);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule